// File: doc/BRIEF.md
# Level-Limited Translation Table Probe

This block answers status queries for a paged memory management unit without changing any translation state. A privileged request gives a logical address, a read/write flag, a search depth from 0 to 7 and a function code. The function code is drawn from one of four sources. A depth of 0 asks for a one-cycle check of the translation cache and the transparent windows only. A depth of 1 to 7 ignores the cache and walks the descriptor tables in memory through a read-only request/response port. The walk stops at the requested depth or at the first fault.

The result is a status word that stays on its output until the next probe ends, and a one-cycle done pulse. When the caller asks for it, the block also returns the physical address of the last descriptor fetched. The cache entries and window settings are driven in from the surrounding unit as plain signals. The probe only reads them, so the cache has no fill path here. The memory port carries no write, so used and modified bits are never updated. A request from user mode is refused with a one-cycle trap pulse.

Top module: `xlat_probe`

## Requirements
- R1: A request accepted while idle with `req_super` low produces a one-cycle `trap` pulse in the next cycle. It produces no `done`, no memory read and no change of `status`.
- R2: While `busy` is high, `req` is ignored: no trap, no restart, and the running probe finishes with its own result.
- R3: The function code is chosen by `req_fc_sel`: 0 takes `req_fc_imm`, 1 takes `req_dreg_fc`, 2 takes `sfc`, 3 takes `dfc`.
- R4: At depth 0, `done` rises two clock edges after the accepting edge and no memory read is issued. The cache hit flag is set when a valid entry has an equal function code and an equal page (address bits 31:4). The write-protect flag is taken from the lowest-numbered matching entry.
- R5: At depth 0, a window hits when it is enabled and address bits 31:24 equal its base on every bit that its mask leaves clear. It must also match the read/write flag when its check bit is set. This is the only way a read probe and a write probe of the same address can differ.
- R6: At depth L ≥ 1, level k reads the descriptor at base + 4·index_k, where index_k is address bits [31−4(k−1) -: 4]. The first base is `root_ptr`, and each next base is descriptor bits 31:16 followed by 16 zero bits. Without a fault exactly L reads are made and the level count equals L.
- R7: A fetched descriptor whose bit 0 is clear or whose bits 7:3 are not all zero ends the walk with the invalid flag.
- R8: A valid descriptor that is not the last one requested ends the walk with the limit flag when the next level's index exceeds descriptor bits 15:8.
- R9: A read answered with `mem_berr` ends the walk with the bus-error flag. The descriptor data of that read is not used.
- R10: The write-protect flag of a walk is the OR of bit 2 of every valid descriptor fetched.
- R11: `phys_valid` pulses with `done` only for a depth ≥ 1 probe that had `req_want_addr` set. `phys_addr` then holds the address of the last descriptor read.
- R12: `status` holds bit 0 cache hit, bit 1 window hit, bit 2 invalid, bit 3 limit, bit 4 bus error, bit 5 write-protect and bits 8:6 the levels searched. It is zero after reset and holds its value between probes. `done` lasts one cycle.
- R13: `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Probe request, sampled while idle |
| req_super | input | 1 | Requester is privileged |
| req_write | input | 1 | 1 for a write probe, 0 for a read probe |
| req_level | input | 3 | Search depth 0..7 |
| req_fc_sel | input | 2 | Function-code source select |
| req_fc_imm | input | 3 | Immediate function code |
| req_dreg_fc | input | 3 | Low bits of the supplied data word |
| req_want_addr | input | 1 | Return the last descriptor address |
| req_va | input | 32 | Logical address to probe |
| sfc | input | 3 | Source function-code register |
| dfc | input | 3 | Destination function-code register |
| root_ptr | input | 32 | Base of the first-level table |
| cache_vld | input | 4 | Cache entry valid bits |
| cache_fc | input | 12 | Cache entry function codes, 3 bits each |
| cache_page | input | 112 | Cache entry pages, 28 bits each |
| cache_wp | input | 4 | Cache entry write-protect bits |
| tt_en | input | 2 | Window enables |
| tt_base | input | 16 | Window bases, 8 bits each |
| tt_mask | input | 16 | Window don't-care masks, 8 bits each |
| tt_rw_chk | input | 2 | Window qualifies on read/write |
| tt_write | input | 2 | Direction a qualified window accepts |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Descriptor data |
| mem_berr | input | 1 | Read ended in a bus error |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Status valid pulse |
| trap | output | 1 | Privilege trap pulse |
| status | output | 9 | Probe status word |
| phys_addr | output | 32 | Last descriptor address |
| phys_valid | output | 1 | `phys_addr` valid pulse |

## Verification
Duplicate cache entries with different write-protect bits target priority. A design that picked the wrong entry would report the wrong protection at depth 0. A write-qualified window probed both ways catches a design that compares the wrong direction or that lets read and write probes differ through the cache. Faults are placed at chosen levels, with a limit hit one level before the last, a bus error in the middle and a reserved-bit descriptor. These catch a walk that stops one level late, counts levels off by one, or keeps walking past a bus error, and each would show up in the level count, the read count or `phys_addr`. A user-mode request during a long walk catches a design that traps or restarts while busy.

// File: rtl/xlat_probe_pkg.sv
package xlat_probe_pkg;

   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_LOOK  = 2'd1,
      PS_FETCH = 2'd2
   } probe_st_e;

   typedef enum logic [1:0] {
      FCS_IMM  = 2'd0,
      FCS_DREG = 2'd1,
      FCS_SRC  = 2'd2,
      FCS_DST  = 2'd3
   } fc_src_e;

   // status word bit positions
   localparam int ST_HIT  = 0;
   localparam int ST_TT   = 1;
   localparam int ST_INV  = 2;
   localparam int ST_LIM  = 3;
   localparam int ST_BERR = 4;
   localparam int ST_WP   = 5;
   localparam int ST_LVL  = 6;
   localparam int FLAG_N  = 6;

endpackage

// File: rtl/xlat_fc_sel.sv
module xlat_fc_sel
   import xlat_probe_pkg::*;
#(
   parameter int FC_W = 3
) (
   input  logic [1:0]      sel,
   input  logic [FC_W-1:0] imm,
   input  logic [FC_W-1:0] dreg,
   input  logic [FC_W-1:0] sfc,
   input  logic [FC_W-1:0] dfc,
   output logic [FC_W-1:0] fc
);

   always_comb begin
      unique case (fc_src_e'(sel))
         FCS_IMM:  fc = imm;
         FCS_DREG: fc = dreg;
         FCS_SRC:  fc = sfc;
         default:  fc = dfc;
      endcase
   end

endmodule

// File: rtl/xlat_l0_lookup.sv
module xlat_l0_lookup #(
   parameter int N      = 4,
   parameter int FC_W   = 3,
   parameter int PAGE_W = 28,
   parameter int TT_N   = 2,
   parameter int TT_W   = 8
) (
   input  logic [FC_W-1:0]      fc,
   input  logic [PAGE_W-1:0]    page,
   input  logic [TT_W-1:0]      tt_key,
   input  logic                 wr,
   input  logic [N-1:0]         cache_vld,
   input  logic [N*FC_W-1:0]    cache_fc,
   input  logic [N*PAGE_W-1:0]  cache_page,
   input  logic [N-1:0]         cache_wp,
   input  logic [TT_N-1:0]      tt_en,
   input  logic [TT_N*TT_W-1:0] tt_base,
   input  logic [TT_N*TT_W-1:0] tt_mask,
   input  logic [TT_N-1:0]      tt_rw_chk,
   input  logic [TT_N-1:0]      tt_write,
   output logic                 hit,
   output logic                 hit_wp,
   output logic                 tt_hit
);

   logic [N-1:0]    ent_match;
   logic [TT_N-1:0] win_match;

   for (genvar e = 0; e < N; e++) begin : g_ent
      assign ent_match[e] = cache_vld[e]
                          && (cache_fc[e*FC_W +: FC_W] == fc)
                          && (cache_page[e*PAGE_W +: PAGE_W] == page);
   end

   for (genvar w = 0; w < TT_N; w++) begin : g_win
      assign win_match[w] = tt_en[w]
                          && (((tt_key ^ tt_base[w*TT_W +: TT_W]) & ~tt_mask[w*TT_W +: TT_W]) == '0)
                          && (!tt_rw_chk[w] || (tt_write[w] == wr));
   end

   // lowest-numbered match wins: scan from the top so it overwrites last
   always_comb begin
      hit_wp = 1'b0;
      for (int e = N - 1; e >= 0; e--) begin
         if (ent_match[e]) hit_wp = cache_wp[e];
      end
   end

   assign hit    = |ent_match;
   assign tt_hit = |win_match;

endmodule

// File: rtl/xlat_desc_eval.sv
module xlat_desc_eval #(
   parameter int DESC_W = 32,
   parameter int PA_W   = 32,
   parameter int IDX_W  = 4,
   parameter int ALIGN  = 16
) (
   input  logic [DESC_W-1:0] desc,
   input  logic              berr,
   input  logic              last,
   input  logic [IDX_W-1:0]  next_idx,
   output logic              stop,
   output logic              f_inv,
   output logic              f_lim,
   output logic              f_berr,
   output logic              wp,
   output logic [PA_W-1:0]   next_base
);

   localparam int V_BIT   = 0;
   localparam int WP_BIT  = 2;
   localparam int RSV_LSB = 3;
   localparam int RSV_W   = 5;
   localparam int LIM_LSB = RSV_LSB + RSV_W;
   localparam int LIM_W   = 8;

   logic             ok;
   logic [LIM_W-1:0] lim;

   assign ok        = desc[V_BIT] && (desc[RSV_LSB +: RSV_W] == '0);
   assign lim       = desc[LIM_LSB +: LIM_W];
   assign f_berr    = berr;
   assign f_inv     = !berr && !ok;
   assign f_lim     = !berr && ok && !last && (LIM_W'(next_idx) > lim);
   assign wp        = !berr && ok && desc[WP_BIT];
   assign stop      = f_berr || f_inv || f_lim;
   assign next_base = PA_W'({desc[DESC_W-1:ALIGN], {ALIGN{1'b0}}});

endmodule

// File: rtl/xlat_probe.sv
module xlat_probe
   import xlat_probe_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int IDX_W     = 4,
   parameter int LVL_W     = 3,
   parameter int FC_W      = 3,
   parameter int CACHE_N   = 4,
   parameter int TT_N      = 2,
   parameter int TT_W      = 8,
   parameter int TBL_ALIGN = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req,
   input  logic                      req_super,
   input  logic                      req_write,
   input  logic [LVL_W-1:0]          req_level,
   input  logic [1:0]                req_fc_sel,
   input  logic [FC_W-1:0]           req_fc_imm,
   input  logic [FC_W-1:0]           req_dreg_fc,
   input  logic                      req_want_addr,
   input  logic [VA_W-1:0]           req_va,
   input  logic [FC_W-1:0]           sfc,
   input  logic [FC_W-1:0]           dfc,
   input  logic [PA_W-1:0]           root_ptr,
   input  logic [CACHE_N-1:0]        cache_vld,
   input  logic [CACHE_N*FC_W-1:0]   cache_fc,
   input  logic [CACHE_N*((2**LVL_W-1)*IDX_W)-1:0] cache_page,
   input  logic [CACHE_N-1:0]        cache_wp,
   input  logic [TT_N-1:0]           tt_en,
   input  logic [TT_N*TT_W-1:0]      tt_base,
   input  logic [TT_N*TT_W-1:0]      tt_mask,
   input  logic [TT_N-1:0]           tt_rw_chk,
   input  logic [TT_N-1:0]           tt_write,
   output logic                      mem_req,
   output logic [PA_W-1:0]           mem_addr,
   input  logic                      mem_rvalid,
   input  logic [31:0]               mem_rdata,
   input  logic                      mem_berr,
   output logic                      busy,
   output logic                      done,
   output logic                      trap,
   output logic [FLAG_N+LVL_W-1:0]   status,
   output logic [PA_W-1:0]           phys_addr,
   output logic                      phys_valid
);

   localparam int MAX_LVL = 2**LVL_W - 1;
   localparam int PAGE_W  = MAX_LVL * IDX_W;
   localparam int STAT_W  = FLAG_N + LVL_W;
   localparam int DESC_W  = 32;

   if (PAGE_W > VA_W) begin : g_bad_page
      $error("xlat_probe: table indices need more address bits than VA_W");
   end
   if (IDX_W > 8) begin : g_bad_idx
      $error("xlat_probe: IDX_W exceeds the descriptor limit field");
   end
   if (TT_W > VA_W) begin : g_bad_tt
      $error("xlat_probe: window key wider than the address");
   end
   if (PA_W > DESC_W || PA_W <= TBL_ALIGN) begin : g_bad_pa
      $error("xlat_probe: PA_W must lie above TBL_ALIGN and within a descriptor");
   end
   if (IDX_W + 2 > TBL_ALIGN) begin : g_bad_align
      $error("xlat_probe: table does not fit its alignment");
   end

   probe_st_e          st_q;
   logic [VA_W-1:0]    va_q;
   logic [FC_W-1:0]    fc_q;
   logic               wr_q;
   logic               want_q;
   logic [LVL_W-1:0]   tgt_q;
   logic [LVL_W-1:0]   cur_q;
   logic [PA_W-1:0]    base_q;
   logic               wp_acc_q;
   logic [STAT_W-1:0]  status_q;
   logic [PA_W-1:0]    phys_q;
   logic               done_q;
   logic               trap_q;
   logic               pvld_q;

   logic [FC_W-1:0]    fc_new;
   logic               c_hit, c_wp, w_hit;
   logic [IDX_W-1:0]   cur_idx, nxt_idx;
   logic               last_lvl;
   logic               ev_stop, ev_inv, ev_lim, ev_berr, ev_wp;
   logic [PA_W-1:0]    ev_base;
   logic [STAT_W-1:0]  l0_st, wk_st;

   function automatic logic [IDX_W-1:0] lvl_slice(input logic [VA_W-1:0] va, input int lvl);
      int sh;
      sh = VA_W - lvl * IDX_W;
      if (sh < 0) sh = 0;
      return IDX_W'(va >> sh);
   endfunction

   xlat_fc_sel #(.FC_W(FC_W)) i_fc_sel (
      .sel  (req_fc_sel),
      .imm  (req_fc_imm),
      .dreg (req_dreg_fc),
      .sfc  (sfc),
      .dfc  (dfc),
      .fc   (fc_new)
   );

   xlat_l0_lookup #(
      .N(CACHE_N), .FC_W(FC_W), .PAGE_W(PAGE_W), .TT_N(TT_N), .TT_W(TT_W)
   ) i_l0 (
      .fc         (fc_q),
      .page       (va_q[VA_W-1 -: PAGE_W]),
      .tt_key     (va_q[VA_W-1 -: TT_W]),
      .wr         (wr_q),
      .cache_vld  (cache_vld),
      .cache_fc   (cache_fc),
      .cache_page (cache_page),
      .cache_wp   (cache_wp),
      .tt_en      (tt_en),
      .tt_base    (tt_base),
      .tt_mask    (tt_mask),
      .tt_rw_chk  (tt_rw_chk),
      .tt_write   (tt_write),
      .hit        (c_hit),
      .hit_wp     (c_wp),
      .tt_hit     (w_hit)
   );

   assign cur_idx  = lvl_slice(va_q, int'(cur_q));
   assign nxt_idx  = lvl_slice(va_q, int'(cur_q) + 1);
   assign last_lvl = (cur_q == tgt_q);

   xlat_desc_eval #(
      .DESC_W(DESC_W), .PA_W(PA_W), .IDX_W(IDX_W), .ALIGN(TBL_ALIGN)
   ) i_eval (
      .desc      (mem_rdata),
      .berr      (mem_berr),
      .last      (last_lvl),
      .next_idx  (nxt_idx),
      .stop      (ev_stop),
      .f_inv     (ev_inv),
      .f_lim     (ev_lim),
      .f_berr    (ev_berr),
      .wp        (ev_wp),
      .next_base (ev_base)
   );

   assign mem_req  = (st_q == PS_FETCH);
   assign mem_addr = base_q + (PA_W'(cur_idx) << 2);

   always_comb begin
      l0_st          = '0;
      l0_st[ST_HIT]  = c_hit;
      l0_st[ST_TT]   = w_hit;
      l0_st[ST_WP]   = c_hit && c_wp;
      wk_st          = '0;
      wk_st[ST_INV]  = ev_inv;
      wk_st[ST_LIM]  = ev_lim;
      wk_st[ST_BERR] = ev_berr;
      wk_st[ST_WP]   = wp_acc_q || ev_wp;
      wk_st[ST_LVL +: LVL_W] = cur_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PS_IDLE;
         va_q     <= '0;
         fc_q     <= '0;
         wr_q     <= 1'b0;
         want_q   <= 1'b0;
         tgt_q    <= '0;
         cur_q    <= '0;
         base_q   <= '0;
         wp_acc_q <= 1'b0;
         status_q <= '0;
         phys_q   <= '0;
         done_q   <= 1'b0;
         trap_q   <= 1'b0;
         pvld_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         trap_q <= 1'b0;
         pvld_q <= 1'b0;
         unique case (st_q)
            PS_IDLE: begin
               if (req) begin
                  if (!req_super) begin
                     trap_q <= 1'b1;
                  end else begin
                     va_q     <= req_va;
                     fc_q     <= fc_new;
                     wr_q     <= req_write;
                     want_q   <= req_want_addr;
                     tgt_q    <= req_level;
                     cur_q    <= LVL_W'(1);
                     base_q   <= root_ptr;
                     wp_acc_q <= 1'b0;
                     st_q     <= (req_level == '0) ? PS_LOOK : PS_FETCH;
                  end
               end
            end
            PS_LOOK: begin
               status_q <= l0_st;
               done_q   <= 1'b1;
               st_q     <= PS_IDLE;
            end
            PS_FETCH: begin
               if (mem_rvalid) begin
                  if (ev_stop || last_lvl) begin
                     status_q <= wk_st;
                     phys_q   <= mem_addr;
                     pvld_q   <= want_q;
                     done_q   <= 1'b1;
                     st_q     <= PS_IDLE;
                  end else begin
                     wp_acc_q <= wp_acc_q || ev_wp;
                     base_q   <= ev_base;
                     cur_q    <= cur_q + LVL_W'(1);
                  end
               end
            end
            default: st_q <= PS_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != PS_IDLE);
   assign done       = done_q;
   assign trap       = trap_q;
   assign status     = status_q;
   assign phys_addr  = phys_q;
   assign phys_valid = pvld_q;

endmodule

// File: rtl/xlat_probe_chk.sv
module xlat_probe_chk #(
   parameter int LVL_W  = 3,
   parameter int PA_W   = 32,
   parameter int STAT_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              req_super,
   input logic [LVL_W-1:0]  req_level,
   input logic              busy,
   input logic              done,
   input logic              trap,
   input logic [STAT_W-1:0] status,
   input logic              mem_req,
   input logic [PA_W-1:0]   mem_addr,
   input logic              mem_rvalid,
   input logic              phys_valid
);

   localparam int LV_LSB = STAT_W - LVL_W;

   logic [LVL_W-1:0] asked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          asked_q <= '0;
      else if (req && !busy && req_super)  asked_q <= req_level;
   end

   // R1
   trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy && !req_super) |=> (trap && !busy && !done));

   // R2
   trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> $past(req && !busy && !req_super));

   // R4
   l0_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy && req_super && req_level == '0) |=> (busy && !mem_req) ##1 done);

   // R13
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   phys_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phys_valid |-> done);

   // R6
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status[LV_LSB +: LVL_W] <= asked_q));

endmodule

bind xlat_probe xlat_probe_chk #(
   .LVL_W(LVL_W), .PA_W(PA_W), .STAT_W(STAT_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req        (req),
   .req_super  (req_super),
   .req_level  (req_level),
   .busy       (busy),
   .done       (done),
   .trap       (trap),
   .status     (status),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .phys_valid (phys_valid)
);

// File: tb/test_xlat_probe.sv
`timescale 1ns/1ps
module test_xlat_probe;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req = 1'b0, req_super = 1'b0, req_write = 1'b0, req_want_addr = 1'b0;
   logic [2:0]   req_level = '0, req_fc_imm = '0, req_dreg_fc = '0, sfc = '0, dfc = '0;
   logic [1:0]   req_fc_sel = '0;
   logic [31:0]  req_va = '0, root_ptr = 32'h0001_0000;
   logic [3:0]   cache_vld = '0, cache_wp = '0;
   logic [11:0]  cache_fc = '0;
   logic [111:0] cache_page = '0;
   logic [1:0]   tt_en = '0, tt_rw_chk = '0, tt_write = '0;
   logic [15:0]  tt_base = '0, tt_mask = '0;
   logic         mem_req, mem_rvalid = 1'b0, mem_berr = 1'b0;
   logic [31:0]  mem_addr, mem_rdata = '0;
   logic         busy, done, trap, phys_valid;
   logic [8:0]   status;
   logic [31:0]  phys_addr;

   int n_chk = 0, n_fail = 0, rd_cnt = 0;
   int mode = 0;
   logic [31:0] salt = '0, ov_addr = '0, ov_desc = '0;
   bit ov_on = 0, ov_berr = 0;

   always #4 clk = ~clk;

   xlat_probe i_xlat_probe (.*);

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] hsh(input logic [31:0] a);
      logic [31:0] h;
      h = (a ^ salt) * 32'h9E37_79B1;
      return h ^ (h >> 15);
   endfunction

   function automatic logic [31:0] mem_desc(input logic [31:0] a);
      logic [31:0] h;
      h = hsh(a);
      if (ov_on && a == ov_addr) return ov_desc;
      if (mode == 0) return {h[31:16], 8'hFF, 8'h01};
      return {h[31:16], (h[8:6] == 0) ? {4'h0, h[12:9]} : 8'h0F,
              (h[18:17] == 0) ? 5'h04 : 5'h00, (h[5:4] == 0), 1'b0, (h[3:0] != 0)};
   endfunction

   function automatic bit mem_be(input logic [31:0] a);
      logic [31:0] h;
      h = hsh(a);
      if (ov_on && a == ov_addr) return ov_berr;
      if (mode == 0) return 1'b0;
      return (h[15:13] == 0) && h[2];
   endfunction

   function automatic logic [31:0] idx(input logic [31:0] va, input int l);
      return (va >> (32 - 4 * l)) & 32'hF;
   endfunction

   // address of the level-l descriptor on a fault-free path
   function automatic logic [31:0] lvl_addr(input logic [31:0] va, input int l);
      logic [31:0] b;
      b = root_ptr;
      for (int k = 1; k < l; k++) b = {mem_desc(b + (idx(va, k) << 2)) >> 16, 16'h0};
      return b + (idx(va, l) << 2);
   endfunction

   function automatic logic [8:0] ref_walk(input logic [31:0] va, input int lvl, output logic [31:0] last);
      logic [31:0] b, a, d;
      logic [8:0] st;
      bit wp;
      b = root_ptr; wp = 0; st = '0; last = '0;
      for (int l = 1; l <= lvl; l++) begin
         a = b + (idx(va, l) << 2);
         last = a;
         d = mem_desc(a);
         st[8:6] = 3'(l);
         if (mem_be(a)) begin st[4] = 1; st[5] = wp; return st; end
         if (!d[0] || d[7:3] != 0) begin st[2] = 1; st[5] = wp; return st; end
         wp = wp | d[2];
         st[5] = wp;
         if (l == lvl) return st;
         if (idx(va, l + 1) > {24'h0, d[15:8]}) begin st[3] = 1; return st; end
         b = {d[31:16], 16'h0};
      end
      return st;
   endfunction

   function automatic logic [8:0] ref_l0(input logic [31:0] va, input logic [2:0] fc, input bit wr);
      logic [8:0] st;
      st = '0;
      for (int e = 3; e >= 0; e--)
         if (cache_vld[e] && cache_fc[e*3 +: 3] == fc && cache_page[e*28 +: 28] == va[31:4]) begin
            st[0] = 1; st[5] = cache_wp[e];
         end
      for (int w = 0; w < 2; w++)
         if (tt_en[w] && ((va[31:24] ^ tt_base[w*8 +: 8]) & ~tt_mask[w*8 +: 8]) == 0 &&
             (!tt_rw_chk[w] || tt_write[w] == wr)) st[1] = 1;
      return st;
   endfunction

   // memory model: answers one half cycle after a request is seen
   initial begin
      forever begin
         @(negedge clk);
         if (mem_rvalid) mem_rvalid = 1'b0;
         else if (mem_req) begin
            mem_rdata  = mem_desc(mem_addr);
            mem_berr   = mem_be(mem_addr);
            mem_rvalid = 1'b1;
            rd_cnt++;
         end
      end
   end

   task automatic probe(input bit sup, input bit wr, input int lvl, input logic [1:0] sel,
                        input logic [2:0] imm, input logic [2:0] dr, input bit want,
                        input logic [31:0] va, input int poke_at, input string tag);
      logic [2:0]  fc;
      logic [8:0]  exp_st, prev;
      logic [31:0] exp_last;
      int n;
      bit got_done, seen_trap;
      case (sel)
         2'd0: fc = imm;
         2'd1: fc = dr;
         2'd2: fc = sfc;
         default: fc = dfc;
      endcase
      exp_last = '0;
      exp_st = (lvl == 0) ? ref_l0(va, fc, wr) : ref_walk(va, lvl, exp_last);
      prev = status;
      @(negedge clk);
      req = 1; req_super = sup; req_write = wr; req_level = 3'(lvl); req_fc_sel = sel;
      req_fc_imm = imm; req_dreg_fc = dr; req_want_addr = want; req_va = va; rd_cnt = 0;
      @(negedge clk);
      req = 0;
      if (!sup) begin
         check(trap === 1'b1, {tag, " R1 trap"}, trap, 1);
         got_done = 0;
         for (int k = 0; k < 4; k++) begin @(negedge clk); if (done || trap || busy) got_done = 1; end
         check(!got_done && rd_cnt == 0 && status == prev, {tag, " R1 quiet"},
               {got_done, 23'h0, rd_cnt[7:0], 23'h0, status}, {32'h0, 23'h0, prev});
         return;
      end
      n = 0; seen_trap = 0;
      while (!done && n < 300) begin
         if (trap) seen_trap = 1;
         if (n == poke_at) begin req = 1; req_super = 0; req_level = 0; end
         else req = 0;
         @(negedge clk);
         n++;
      end
      req = 0;
      if (n >= 300) begin check(0, {tag, " watchdog"}, n, 0); return; end
      check(status == exp_st, {tag, " status"}, status, exp_st);
      check(phys_valid == (want && lvl != 0), {tag, " R11 strobe"}, phys_valid, want && lvl != 0);
      if (want && lvl != 0) check(phys_addr == exp_last, {tag, " R11 addr"}, phys_addr, exp_last);
      if (lvl == 0) check(n == 1 && rd_cnt == 0, {tag, " R4 timing/no read"}, {n[31:0], rd_cnt[31:0]}, 64'h1_0000_0000);
      else check(rd_cnt == int'(exp_st[8:6]), {tag, " R6 reads"}, rd_cnt, exp_st[8:6]);
      if (poke_at >= 0) check(!seen_trap && !trap, {tag, " R2 busy ignore"}, seen_trap, 0);
      @(negedge clk);
      check(!done && status == exp_st, {tag, " R12 hold"}, {done, status}, {1'b0, exp_st});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] pa, pb, pc, va;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check(status == 0 && !busy && !done && !trap && !phys_valid, "R12 reset", {busy, done, trap, status}, 0);
      check(!mem_req, "R13 reset", mem_req, 0);
      rst_n = 1;
      @(negedge clk);

      pa = 32'h1234_5670; pb = 32'h7654_3210; pc = 32'h0ABC_DEF0;
      cache_vld  = 4'b0111;
      cache_fc   = {3'd3, 3'd1, 3'd5, 3'd5};
      cache_page = {pc[31:4], pb[31:4], pa[31:4], pa[31:4]};
      cache_wp   = 4'b0001;
      sfc = 3'd5; dfc = 3'd2;
      probe(1, 0, 0, 2'd0, 3'd5, 3'd0, 1, pa, -1, "R4 priority hit");
      probe(1, 0, 0, 2'd1, 3'd0, 3'd5, 0, pa, -1, "R3 dreg source");
      probe(1, 1, 0, 2'd2, 3'd0, 3'd0, 0, pa, -1, "R3 sfc source");
      probe(1, 0, 0, 2'd3, 3'd5, 3'd5, 0, pa, -1, "R3 dfc source miss");
      probe(1, 0, 0, 2'd0, 3'd3, 3'd0, 0, pc, -1, "R4 invalid entry miss");
      probe(1, 0, 0, 2'd0, 3'd1, 3'd0, 0, pb, -1, "R4 single hit");

      tt_en = 2'b01; tt_base = 16'h00A0; tt_mask = 16'h000F; tt_rw_chk = 2'b01; tt_write = 2'b01;
      probe(1, 1, 0, 2'd0, 3'd0, 3'd0, 0, 32'hA300_0000, -1, "R5 window write");
      probe(1, 0, 0, 2'd0, 3'd0, 3'd0, 0, 32'hA300_0000, -1, "R5 window read");
      check(ref_l0(32'hA300_0000, 0, 1) != ref_l0(32'hA300_0000, 0, 0), "R5 model differs", 0, 1);

      mode = 0; salt = 32'h5A5A_1234;
      probe(1, 0, 3, 2'd0, 3'd0, 3'd0, 1, 32'h3C1F_2E40, -1, "R6 walk 3");
      probe(1, 1, 7, 2'd0, 3'd0, 3'd0, 1, 32'hFEDC_BA98, -1, "R6 walk 7");
      probe(1, 0, 5, 2'd0, 3'd0, 3'd0, 0, 32'h1111_2222, -1, "R11 no address wanted");

      va = 32'h2345_6789;
      ov_addr = lvl_addr(va, 2); ov_desc = 32'h0000_FF00; ov_berr = 0; ov_on = 1;
      probe(1, 0, 6, 2'd0, 3'd0, 3'd0, 1, va, -1, "R7 invalid at level 2");
      ov_on = 0; ov_addr = lvl_addr(va, 3); ov_desc = 32'h4444_FF09; ov_on = 1;
      probe(1, 0, 6, 2'd0, 3'd0, 3'd0, 1, va, -1, "R7 reserved bits at level 3");
      va = 32'h1900_0000;
      ov_on = 0; ov_addr = lvl_addr(va, 1); ov_desc = 32'h1234_0301; ov_on = 1;
      probe(1, 0, 4, 2'd0, 3'd0, 3'd0, 1, va, -1, "R8 limit after level 1");
      probe(1, 0, 1, 2'd0, 3'd0, 3'd0, 1, va, -1, "R8 limit unused at last level");
      va = 32'h7A5B_3C2D;
      ov_on = 0; ov_addr = lvl_addr(va, 3); ov_desc = 32'hFFFF_FF01; ov_berr = 1; ov_on = 1;
      probe(1, 1, 7, 2'd0, 3'd0, 3'd0, 1, va, -1, "R9 bus error at level 3");
      ov_on = 0; ov_addr = lvl_addr(va, 2); ov_desc = 32'h2222_FF05; ov_berr = 0; ov_on = 1;
      probe(1, 0, 4, 2'd0, 3'd0, 3'd0, 1, va, -1, "R10 write-protect at level 2");
      ov_on = 0;

      probe(0, 0, 3, 2'd0, 3'd0, 3'd0, 1, va, -1, "R1 user request");
      probe(1, 0, 7, 2'd0, 3'd0, 3'd0, 1, 32'hC0FF_EE00, 3, "R2 poke while busy");

      for (int i = 0; i < 300; i++) begin
         logic [2:0] f;
         int e;
         if (i % 25 == 0) begin
            cache_vld = 4'($urandom); cache_wp = 4'($urandom); cache_fc = 12'($urandom);
            cache_page = {28'($urandom), 28'($urandom), 28'($urandom), 28'($urandom)};
            tt_en = 2'($urandom); tt_base = 16'($urandom); tt_mask = 16'($urandom) & 16'h0F0F;
            tt_rw_chk = 2'($urandom); tt_write = 2'($urandom);
            root_ptr = {16'($urandom), 16'h0};
            sfc = 3'($urandom); dfc = 3'($urandom);
         end
         mode = 1; salt = $urandom;
         e = $urandom % 4;
         va = ($urandom % 2 == 0) ? {cache_page[e*28 +: 28], 4'($urandom)} : $urandom;
         f = ($urandom % 2 == 0) ? cache_fc[e*3 +: 3] : 3'($urandom);
         probe(($urandom % 16) != 0, 1'($urandom), $urandom % 8, 2'($urandom), f, f,
               1'($urandom), va, -1, "R6 random probe");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule